// File: doc/BRIEF.md
# Stream Gather/Scatter Address Generator

This block turns one bulk-transfer command into an ordered stream of single-word addresses for a word-addressed main memory. A transfer moves a number of records, each a run of contiguous words. It moves them between sparse locations in main memory and a dense block of local memory. The record start addresses come from one of two sources. In strided modes they are a base plus a fixed stride per record. In indexed modes the base is offset by absolute indexes that an external FIFO supplies, one per record.

The order of the addresses is chosen so that a downstream packer can build 128-bit local-memory words that feed short-vector SIMD units directly. Records are taken in groups of two or four. For each field of the record, the same field of every record in the group is issued before moving on to the next field. Each beat carries two address lanes, so a group of four needs two beats per local-memory word. Every beat is tagged with its local-memory word number, with which half of that word it fills, and with the transfer direction. A scatter-add flag tells downstream logic to do a read-modify-write instead of a plain write. A one-cycle done pulse closes each command.

Top module: `stream_addr_gen`

## Requirements
- R1: Out of reset, cmd_ready is 1, and out_valid and done are 0. cmd_ready is 1 only while no command is in progress, and a command is taken on a clock edge where cmd_valid and cmd_ready are both 1.
- R2: Mode codes are: 0 strided gather, 1 strided scatter, 2 indexed gather, 3 indexed scatter, 4 scatter-add, which is indexed. Codes 5 to 7 act as 4. On every beat, out_write is 1 for codes 1, 3 and 4, and out_add is 1 only for code 4.
- R3: In strided modes, record r (counted from 0) starts at base + r*stride, taken modulo 2^AW.
- R4: In indexed modes, record r starts at base + the r-th index taken from the FIFO, modulo 2^AW. Exactly one index is popped per record, in record order. idx_ready is never 1 in a strided mode.
- R5: The addresses of a record are start+f for f = 0 .. W-1, where W is cmd_rec_words. A value of 0 for cmd_rec_words is treated as 1.
- R6: The group size G is 2 when cmd_pack4=0 and 4 when cmd_pack4=1. Groups are walked in order, and fields within a group in ascending order. For one field, the beat with out_half=0 carries lanes 0 and 1 of the group, and the beat with out_half=1 carries lanes 2 and 3. out_addr0 is the even lane and out_addr1 the odd lane.
- R7: out_slot numbers the local-memory words of a command. It starts at 0 and equals group*W + field.
- R8: out_lane_vld bit 0 belongs to out_addr0 and bit 1 to out_addr1. A lane with no record behind it, which happens only in the last group, has its bit at 0. When G=4 and the last group holds at most two records, no out_half=1 beat is issued for that group.
- R9: While out_valid=1 and out_ready=0, every beat output holds its value. While idx_valid=0, the walk waits and no index is consumed. No address is lost or repeated.
- R10: done is 1 for exactly the cycle after the edge that accepts the last beat. A command with cmd_count=0 issues no beat, and its done pulse comes in the cycle after the command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Generator idle, command can be taken |
| cmd_mode | input | 3 | Transfer mode code |
| cmd_base | input | AW | Base word address |
| cmd_rec_words | input | FW | Words per record |
| cmd_stride | input | AW | Record spacing in words (strided modes) |
| cmd_count | input | CW | Number of records |
| cmd_pack4 | input | 1 | 1: groups of four records, 0: groups of two |
| idx_valid | input | 1 | Index FIFO not empty |
| idx_ready | output | 1 | Index popped this cycle when idx_valid |
| idx_data | input | AW | Absolute record index |
| out_valid | output | 1 | Beat available |
| out_ready | input | 1 | Downstream accepts the beat |
| out_addr0 | output | AW | Even-lane word address |
| out_addr1 | output | AW | Odd-lane word address |
| out_lane_vld | output | 2 | Per-lane valid |
| out_slot | output | CW+FW | Local-memory 128-bit word number |
| out_half | output | 1 | Which lane pair of the word |
| out_write | output | 1 | 1: write to main memory, 0: read |
| out_add | output | 1 | Scatter-add: read-modify-write |
| done | output | 1 | Command finished pulse |

## Verification
The bench targets padded last groups, including a four-record group with only one or two members. There, a design that miscounts would issue a spurious upper-half beat or flag an empty lane as valid. It holds out_ready low at random and leaves gaps in the index FIFO. A generator that advances on a stalled beat, or that latches the garbage on idx_data while the FIFO is empty, shows up as a shifted or corrupted address. Further cases cover a zero record length, a zero record count, a reserved mode code and an address sum that wraps past the top of the space. Each of these would give a wrong slot, a missing or early done, or a wrong direction flag.

// File: rtl/sag_pkg.sv
// Shared constants, walker state type and mode decoding for the
// stream address generator. Assumes the 3-bit mode code layout of the brief.
package sag_pkg;

    localparam int LANES     = 2;   // addresses per beat
    localparam int GROUP_MAX = 4;   // largest record group

    typedef enum logic [1:0] {
        WS_IDLE = 2'd0,
        WS_LOAD = 2'd1,
        WS_EMIT = 2'd2
    } walk_state_e;

    // Record starts come from the index FIFO
    function automatic logic mode_indexed(input logic [2:0] m);
        return m[2] | m[1];
    endfunction

    // Data flows toward main memory
    function automatic logic mode_write(input logic [2:0] m);
        return m[2] | m[0];
    endfunction

    // Read-modify-write accumulate at the destination
    function automatic logic mode_add(input logic [2:0] m);
        return m[2];
    endfunction

endpackage

// File: rtl/sag_walker.sv
// Command sequencer: walks groups, load steps, fields and lane halves.
// Assumes the top forms cmd_fire = cmd_valid & cmd_ready, and that
// `indexed` stays constant for the whole command.
module sag_walker
    import sag_pkg::*;
#(
    parameter int FW = 4,
    parameter int CW = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_fire,
    input  logic [CW-1:0]        cmd_count,
    input  logic [FW-1:0]        cmd_rec_words,
    input  logic                 cmd_pack4,
    input  logic                 indexed,
    input  logic                 idx_valid,
    input  logic                 out_ready,
    output logic                 cmd_ready,
    output logic                 idx_ready,
    output logic                 load_en,
    output logic [1:0]           load_k,
    output logic                 emit_valid,
    output logic [FW-1:0]        field,
    output logic                 half,
    output logic [CW+FW-1:0]     slot,
    output logic [1:0]           lane_vld,
    output logic                 done
);

    localparam int SW = CW + FW;

    walk_state_e   state_q;
    logic [FW-1:0] rw_q;
    logic [FW-1:0] field_q;
    logic [CW-1:0] rem_q;
    logic [2:0]    grp_n_q;
    logic [1:0]    load_k_q;
    logic          half_q;
    logic          pack4_q;
    logic [SW-1:0] slot_q;
    logic          done_q;

    logic          beat_fire;
    logic          need_upper;
    logic          word_close;
    logic          group_close;
    logic [CW-1:0] rem_after;
    logic          cmd_last;

    // Records in the next group: G, or fewer in the tail
    function automatic logic [2:0] group_size(input logic [CW-1:0] left, input logic four);
        logic [CW-1:0] g;
        g = four ? CW'(4) : CW'(2);
        return (left >= g) ? g[2:0] : left[2:0];
    endfunction

    // Handshake and per-beat decode
    assign cmd_ready   = (state_q == WS_IDLE);
    assign idx_ready   = (state_q == WS_LOAD) && indexed;
    assign load_en     = (state_q == WS_LOAD) && (!indexed || idx_valid);
    assign emit_valid  = (state_q == WS_EMIT);
    assign lane_vld[0] = {1'b0, half_q, 1'b0} < grp_n_q;
    assign lane_vld[1] = {1'b0, half_q, 1'b1} < grp_n_q;
    assign beat_fire   = emit_valid && out_ready;
    assign need_upper  = pack4_q && (grp_n_q > 3'd2);
    assign word_close  = beat_fire && !(need_upper && !half_q);
    assign group_close = word_close && (field_q == rw_q - 1'b1);
    assign rem_after   = rem_q - CW'(grp_n_q);
    assign cmd_last    = group_close && (rem_after == '0);

    assign load_k = load_k_q;
    assign field  = field_q;
    assign half   = half_q;
    assign slot   = slot_q;
    assign done   = done_q;

    // Sequencer state update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= WS_IDLE;
            rw_q     <= FW'(1);
            field_q  <= '0;
            rem_q    <= '0;
            grp_n_q  <= '0;
            load_k_q <= '0;
            half_q   <= 1'b0;
            pack4_q  <= 1'b0;
            slot_q   <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                WS_IDLE: begin
                    if (cmd_fire) begin
                        rw_q     <= (cmd_rec_words == '0) ? FW'(1) : cmd_rec_words;
                        pack4_q  <= cmd_pack4;
                        rem_q    <= cmd_count;
                        grp_n_q  <= group_size(cmd_count, cmd_pack4);
                        slot_q   <= '0;
                        field_q  <= '0;
                        half_q   <= 1'b0;
                        load_k_q <= '0;
                        if (cmd_count == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            state_q <= WS_LOAD;
                        end
                    end
                end
                WS_LOAD: begin
                    if (load_en) begin
                        if ({1'b0, load_k_q} == grp_n_q - 3'd1) begin
                            load_k_q <= '0;
                            state_q  <= WS_EMIT;
                        end else begin
                            load_k_q <= load_k_q + 2'd1;
                        end
                    end
                end
                WS_EMIT: begin
                    if (beat_fire) begin
                        if (!word_close) begin
                            half_q <= 1'b1;
                        end else begin
                            half_q <= 1'b0;
                            slot_q <= slot_q + 1'b1;
                            if (!group_close) begin
                                field_q <= field_q + 1'b1;
                            end else begin
                                field_q <= '0;
                                rem_q   <= rem_after;
                                if (cmd_last) begin
                                    done_q  <= 1'b1;
                                    state_q <= WS_IDLE;
                                end else begin
                                    grp_n_q <= group_size(rem_after, pack4_q);
                                    state_q <= WS_LOAD;
                                end
                            end
                        end
                    end
                end
                default: state_q <= WS_IDLE;
            endcase
        end
    end

    AST_BEAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        emit_valid && !out_ready |=> emit_valid && $stable(field_q) && $stable(half_q) && $stable(slot_q))
        else $error("beat changed under stall"); // R9
    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(beat_fire) || $past(cmd_fire))
        else $error("done without cause"); // R10
    AST_LOW_LANE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        emit_valid |-> lane_vld[0])
        else $error("beat with empty low lane"); // R8
    AST_IDX_ONLY_INDEXED: assert property (@(posedge clk) disable iff (!rst_n)
        idx_ready |-> indexed)
        else $error("index pop in strided mode"); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !emit_valid)
        else $error("beat while idle"); // R1

endmodule

// File: rtl/sag_start_file.sv
// Holds the start word address of each record in the current group and
// forms the two lane addresses of a beat. Assumes load_k only names a
// record inside the group and that the walker orders loads by record.
module sag_start_file
    import sag_pkg::*;
#(
    parameter int AW = 32,
    parameter int FW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_fire,
    input  logic [AW-1:0] cmd_base,
    input  logic [AW-1:0] cmd_stride,
    input  logic          indexed,
    input  logic          load_en,
    input  logic [1:0]    load_k,
    input  logic [AW-1:0] idx_data,
    input  logic          half,
    input  logic [FW-1:0] field,
    output logic [AW-1:0] addr0,
    output logic [AW-1:0] addr1
);

    logic [AW-1:0] base_q;
    logic [AW-1:0] stride_q;
    logic [AW-1:0] acc_q;
    logic [AW-1:0] start_q [GROUP_MAX];
    logic [AW-1:0] load_val;
    logic [AW-1:0] lane_addr [LANES];

    // Next record start: indexed offset, or the running strided sum
    assign load_val = indexed ? (base_q + idx_data) : acc_q;

    // Command operands and strided accumulator
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            stride_q <= '0;
            acc_q    <= '0;
        end else if (cmd_fire) begin
            base_q   <= cmd_base;
            stride_q <= cmd_stride;
            acc_q    <= cmd_base;
        end else if (load_en && !indexed) begin
            acc_q <= acc_q + stride_q;
        end
    end

    // Capture one record start per load step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int g = 0; g < GROUP_MAX; g++) begin
                start_q[g] <= '0;
            end
        end else if (load_en) begin
            start_q[load_k] <= load_val;
        end
    end

    // One adder per lane: record start plus field offset
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_addr[l] = start_q[{half, 1'(l)}] + AW'(field);
    end

    assign addr0 = lane_addr[0];
    assign addr1 = lane_addr[1];

endmodule

// File: rtl/stream_addr_gen.sv
// Top level: latches the mode, joins the sequencer and the start file,
// and presents the beat interface. Assumes the index FIFO shows its head
// on idx_data whenever idx_valid is 1.
module stream_addr_gen
    import sag_pkg::*;
#(
    parameter int AW = 32,
    parameter int FW = 4,
    parameter int CW = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [2:0]       cmd_mode,
    input  logic [AW-1:0]    cmd_base,
    input  logic [FW-1:0]    cmd_rec_words,
    input  logic [AW-1:0]    cmd_stride,
    input  logic [CW-1:0]    cmd_count,
    input  logic             cmd_pack4,
    input  logic             idx_valid,
    output logic             idx_ready,
    input  logic [AW-1:0]    idx_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [AW-1:0]    out_addr0,
    output logic [AW-1:0]    out_addr1,
    output logic [1:0]       out_lane_vld,
    output logic [CW+FW-1:0] out_slot,
    output logic             out_half,
    output logic             out_write,
    output logic             out_add,
    output logic             done
);

    logic          cmd_fire;
    logic [2:0]    mode_q;
    logic          indexed;
    logic          load_en;
    logic [1:0]    load_k;
    logic [FW-1:0] field;
    logic          half;

    assign cmd_fire  = cmd_valid && cmd_ready;
    assign indexed   = mode_indexed(mode_q);
    assign out_write = mode_write(mode_q);
    assign out_add   = mode_add(mode_q);
    assign out_half  = half;

    // Mode register, held for the whole command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (cmd_fire) begin
            mode_q <= cmd_mode;
        end
    end

    sag_walker #(.FW(FW), .CW(CW)) u_walker (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_fire      (cmd_fire),
        .cmd_count     (cmd_count),
        .cmd_rec_words (cmd_rec_words),
        .cmd_pack4     (cmd_pack4),
        .indexed       (indexed),
        .idx_valid     (idx_valid),
        .out_ready     (out_ready),
        .cmd_ready     (cmd_ready),
        .idx_ready     (idx_ready),
        .load_en       (load_en),
        .load_k        (load_k),
        .emit_valid    (out_valid),
        .field         (field),
        .half          (half),
        .slot          (out_slot),
        .lane_vld      (out_lane_vld),
        .done          (done)
    );

    sag_start_file #(.AW(AW), .FW(FW)) u_starts (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_fire   (cmd_fire),
        .cmd_base   (cmd_base),
        .cmd_stride (cmd_stride),
        .indexed    (indexed),
        .load_en    (load_en),
        .load_k     (load_k),
        .idx_data   (idx_data),
        .half       (half),
        .field      (field),
        .addr0      (out_addr0),
        .addr1      (out_addr1)
    );

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> $stable(out_addr0) && $stable(out_addr1) && $stable(out_lane_vld))
        else $error("address changed under stall"); // R9
    AST_DIR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(out_valid) |-> $stable(out_write) && $stable(out_add))
        else $error("direction changed mid-command"); // R2

endmodule

// File: tb/stream_addr_gen_bench.sv
// Behavioural reference bench: expected beats are built in queues from
// the requirements and compared with the design on every clock.
module stream_addr_gen_bench;

    localparam int AW = 32;
    localparam int FW = 4;
    localparam int CW = 12;
    localparam int SW = CW + FW;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n;
    logic          cmd_valid, cmd_ready, cmd_pack4;
    logic [2:0]    cmd_mode;
    logic [AW-1:0] cmd_base, cmd_stride;
    logic [FW-1:0] cmd_rec_words;
    logic [CW-1:0] cmd_count;
    logic          idx_valid, idx_ready;
    logic [AW-1:0] idx_data;
    logic          out_valid, out_ready, out_half, out_write, out_add, done;
    logic [AW-1:0] out_addr0, out_addr1;
    logic [1:0]    out_lane_vld;
    logic [SW-1:0] out_slot;

    int checks = 0;
    int errors = 0;

    typedef struct packed {
        logic [AW-1:0] a0;
        logic [AW-1:0] a1;
        logic [1:0]    vld;
        logic [SW-1:0] slot;
        logic          half;
    } beat_t;

    beat_t         exp_q[$];
    logic [AW-1:0] idx_q[$];

    stream_addr_gen #(.AW(AW), .FW(FW), .CW(CW)) u_stream_addr_gen (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_mode(cmd_mode), .cmd_base(cmd_base), .cmd_rec_words(cmd_rec_words),
        .cmd_stride(cmd_stride), .cmd_count(cmd_count), .cmd_pack4(cmd_pack4),
        .idx_valid(idx_valid), .idx_ready(idx_ready), .idx_data(idx_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr0(out_addr0),
        .out_addr1(out_addr1), .out_lane_vld(out_lane_vld), .out_slot(out_slot),
        .out_half(out_half), .out_write(out_write), .out_add(out_add), .done(done)
    );

    task automatic check_eq(input string req, input string what,
                            input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One command end to end; areq tags the address-source requirement
    task automatic run_cmd(input logic [2:0] mode, input logic [AW-1:0] base,
                           input logic [FW-1:0] rw, input logic [AW-1:0] stride,
                           input int cnt, input bit p4, input int rdy_pct,
                           input int idx_pct, input string areq);
        int gs;
        int rwe;
        bit idxd;
        bit exp_done;
        bit fin;
        bit stalled;
        bit idx_bad;
        int cyc;
        beat_t hold;
        beat_t cur;
        logic [AW-1:0] starts[$];
        gs   = p4 ? 4 : 2;
        rwe  = (rw == '0) ? 1 : int'(rw);
        idxd = mode[2] | mode[1];
        starts.delete();
        exp_q.delete();
        idx_q.delete();
        for (int r = 0; r < cnt; r++) begin
            logic [AW-1:0] r32;
            logic [AW-1:0] v;
            r32 = AW'(r);
            if (idxd) begin
                v = r32 * 32'd4099 + r32 * r32 * 32'd13 + 32'd3;
                idx_q.push_back(v);
                starts.push_back(base + v);
            end else begin
                starts.push_back(base + r32 * stride);
            end
        end
        for (int g = 0; g * gs < cnt; g++) begin
            int n;
            n = (cnt - g * gs >= gs) ? gs : cnt - g * gs;
            for (int f = 0; f < rwe; f++) begin
                for (int h = 0; h < gs / 2; h++) begin
                    beat_t b;
                    if (2 * h < n) begin
                        b.a0   = starts[g * gs + 2 * h] + AW'(f);
                        b.a1   = (2 * h + 1 < n) ? starts[g * gs + 2 * h + 1] + AW'(f) : '0;
                        b.vld  = {(2 * h + 1 < n), 1'b1};
                        b.slot = SW'(g * rwe + f);
                        b.half = h[0];
                        exp_q.push_back(b);
                    end
                end
            end
        end
        @(negedge clk);
        cmd_valid = 1'b1; cmd_mode = mode; cmd_base = base; cmd_rec_words = rw;
        cmd_stride = stride; cmd_count = CW'(cnt); cmd_pack4 = p4;
        #1;
        check_eq("R1", "cmd_ready before accept", 64'(cmd_ready), 64'd1);
        @(negedge clk);
        cmd_valid = 1'b0;
        exp_done = (cnt == 0);
        fin = 1'b0; stalled = 1'b0; idx_bad = 1'b0; cyc = 0;
        while (!fin) begin
            check_eq("R10", "done timing", 64'(done), 64'(exp_done));
            if (done || exp_done) begin
                fin = 1'b1;
            end else begin
                out_ready = ($urandom_range(99) < rdy_pct);
                if (idx_q.size() > 0 && $urandom_range(99) < idx_pct) begin
                    idx_valid = 1'b1; idx_data = idx_q[0];
                end else begin
                    idx_valid = 1'b0; idx_data = 32'hDEAD_BEEF;
                end
                #1;
                cur = '{a0: out_addr0, a1: out_lane_vld[1] ? out_addr1 : '0,
                        vld: out_lane_vld, slot: out_slot, half: out_half};
                if (stalled) begin
                    check_eq("R9", "valid held under stall", 64'(out_valid), 64'd1);
                    check_eq("R9", "beat held under stall", 64'(cur.slot ^ hold.slot) |
                             64'(cur.a0 ^ hold.a0) | 64'(cur.a1 ^ hold.a1), 64'd0);
                end
                if (!idxd && idx_ready) idx_bad = 1'b1;
                if (out_valid) begin
                    if (exp_q.size() == 0) begin
                        check_eq("R8", "unexpected extra beat", 64'd1, 64'd0);
                    end else if (out_ready) begin
                        check_eq(areq, "lane0 address", 64'(out_addr0), 64'(exp_q[0].a0));
                        if (exp_q[0].vld[1])
                            check_eq("R5", "lane1 address", 64'(out_addr1), 64'(exp_q[0].a1));
                        check_eq("R8", "lane valid bits", 64'(out_lane_vld), 64'(exp_q[0].vld));
                        check_eq("R7", "slot number", 64'(out_slot), 64'(exp_q[0].slot));
                        check_eq("R6", "half select", 64'(out_half), 64'(exp_q[0].half));
                        check_eq("R2", "write/add flags", 64'({out_write, out_add}),
                                 64'({mode[2] | mode[0], mode[2]}));
                        void'(exp_q.pop_front());
                        if (exp_q.size() == 0) exp_done = 1'b1;
                    end
                    stalled = !out_ready;
                    hold = cur;
                end else begin
                    stalled = 1'b0;
                end
                if (idx_valid && idx_ready) void'(idx_q.pop_front());
                cyc++;
                if (cyc > 5000) begin
                    check_eq("R9", "command stuck", 64'd1, 64'd0);
                    fin = 1'b1;
                end
                @(negedge clk);
            end
        end
        out_ready = 1'b0; idx_valid = 1'b0;
        check_eq("R10", "beats left after done", 64'(exp_q.size()), 64'd0);
        check_eq("R4", "indexes left or pops in strided mode",
                 64'(idx_q.size()) + 64'(idx_bad), 64'd0);
        #1;
        check_eq("R1", "idle after done", 64'({cmd_ready, out_valid}), 64'b10);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_mode = '0; cmd_base = '0;
        cmd_rec_words = '0; cmd_stride = '0; cmd_count = '0; cmd_pack4 = 1'b0;
        idx_valid = 1'b0; idx_data = '0; out_ready = 1'b0;
        repeat (3) @(negedge clk);
        check_eq("R1", "reset state", 64'({cmd_ready, out_valid, done}), 64'b100);
        rst_n = 1'b1;
        // R3: strided gather, full groups of four, three words per record
        run_cmd(3'd0, 32'h0000_1000, 4'd3, 32'd10, 8, 1'b1, 100, 100, "R3");
        // R3: strided scatter, pairs with odd tail, ready throttled (R9)
        run_cmd(3'd1, 32'h0000_2000, 4'd1, 32'd7, 5, 1'b0, 40, 100, "R3");
        // R4: indexed gather, fours, tail of two skips upper half (R8)
        run_cmd(3'd2, 32'h0001_0000, 4'd2, 32'd0, 6, 1'b1, 70, 50, "R4");
        // R4: indexed scatter, tail of three, sparse index FIFO (R9)
        run_cmd(3'd3, 32'h0002_0000, 4'd2, 32'd0, 7, 1'b1, 60, 25, "R4");
        // R4: tail of one in a group of four (R8)
        run_cmd(3'd2, 32'h0003_0000, 4'd3, 32'd0, 5, 1'b1, 80, 60, "R4");
        // R2: scatter-add in pairs, long records
        run_cmd(3'd4, 32'h0004_0000, 4'd4, 32'd0, 3, 1'b0, 75, 70, "R4");
        // R2: reserved code 6 acts as scatter-add
        run_cmd(3'd6, 32'h0005_0000, 4'd1, 32'd0, 4, 1'b1, 90, 90, "R4");
        // R5: record length zero treated as one
        run_cmd(3'd0, 32'h0006_0000, 4'd0, 32'd3, 6, 1'b1, 100, 100, "R5");
        // R10: empty command
        run_cmd(3'd0, 32'h0007_0000, 4'd2, 32'd5, 0, 1'b1, 100, 100, "R10");
        // R3: address wrap past the top of the space
        run_cmd(3'd1, 32'hFFFF_FFF0, 4'd5, 32'h4000_0001, 9, 1'b1, 50, 100, "R3");
        // R6: pairs with heavy backpressure
        run_cmd(3'd0, 32'h0008_0000, 4'd15, 32'd20, 4, 1'b0, 20, 100, "R6");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule